// File: doc/BRIEF.md
# Hashed Page Table Walker

This engine resolves an address-translation miss by searching a hashed page table held in memory. A requester supplies a segment identifier, the effective page index of the faulting address and a flag that tells whether the access is an instruction fetch or a data access. The engine hashes these values into the address of an eight-entry group of 64-bit table entries. It reads the entries one at a time through a single-outstanding memory read port and compares each one against a key built from the request.

The walk makes a primary pass over one group. If that pass finds nothing, it makes a secondary pass over a second group addressed by the complemented hash, and there it looks only for entries whose pass bit is set. The engine ends with a hit and the full matching entry, or with a page fault. A page fault sets status bit 1 on the fault output that belongs to the access type. A request marked as speculative is parked and starts no memory traffic until the requester confirms that program flow needs it. The result is held until the requester acknowledges it.

Top module: `hpt_walker`

## Requirements
- R1: While reset is applied, and on the first clock after it is released, `done_o` and `mem_req_valid_o` are 0 and `req_ready_o` is 1.
- R2: The primary hash is `vsid[18:0] XOR {3'b0, epi[15:0]}`. The secondary hash is its 19-bit one's complement. The group base address is `{table_org_i | (hash & table_mask_i), 6'b0}`, where `table_org_i` holds address bits 31:6.
- R3: The address of entry k (k = 0..7) of a group is the group base plus 8*k. Entries are read in ascending order, with at most one read outstanding. A read request keeps its address and stays asserted until `mem_req_ready_i` is 1.
- R4: An entry matches only when all of these hold: bit 63 (valid) is 1, bits 62:39 equal the request VSID, bits 37:32 equal `epi[15:10]`, and bit 38 equals the pass in use (0 primary, 1 secondary).
- R5: The secondary pass starts only after all eight primary entries have been read without a match. It then reads the secondary group from entry 0.
- R6: On a match, the engine stops reading and raises `done_o` with `hit_o`=1. It presents the whole 64-bit entry on `pte_o`, and both fault outputs read 0.
- R7: An instruction-fetch request (`req_is_inst_i`=1) that matches nothing in either pass ends after 16 reads with `hit_o`=0 and `inst_fault_o` = 32'h2. `data_fault_o` reads 0.
- R8: A data request that matches nothing in either pass ends after 16 reads with `hit_o`=0 and `data_fault_o` = 32'h2. `inst_fault_o` reads 0.
- R9: A request accepted with `req_spec_i`=1 issues no memory read until `req_required_i` is 1. The first read follows that confirmation.
- R10: `done_o`, `hit_o` and `pte_o` hold until `done_ack_i` is 1. Until then `req_ready_o` is 0, and new requests start no reads. After the acknowledge the engine is idle with `req_ready_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Lookup request strobe, taken when `req_ready_o` is 1 |
| req_ready_o | output | 1 | Engine idle and able to accept a request |
| req_spec_i | input | 1 | Request is speculative and must wait for confirmation |
| req_required_i | input | 1 | Confirms that a parked speculative request is needed |
| req_is_inst_i | input | 1 | 1 for instruction fetch, 0 for data access |
| req_vsid_i | input | 24 | Virtual segment identifier |
| req_epi_i | input | 16 | Effective page index (effective address bits 27:12) |
| table_org_i | input | 26 | Page table origin, address bits 31:6 |
| table_mask_i | input | 19 | Mask applied to the hash |
| mem_req_valid_o | output | 1 | Memory read request |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 32 | Byte address of the entry being read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Read data (one table entry) |
| done_o | output | 1 | Walk finished, result valid |
| done_ack_i | input | 1 | Acknowledges the result |
| hit_o | output | 1 | 1 when a matching entry was found |
| pte_o | output | 64 | Matching table entry |
| inst_fault_o | output | 32 | Instruction-fetch fault status, bit 1 set on fault |
| data_fault_o | output | 32 | Data-access fault status, bit 1 set on fault |

## Verification
The bench places entries at addresses it computes from the hash formula. It then checks the exact sequence of read addresses, so a wrong hash, a wrong stride or a missing complement in the secondary pass shows up as a read of the wrong group. One entry carries the pass bit set inside the primary group, and another carries a clear valid bit but a correct key. A walker that ignored either bit would report a false hit. A miss must show exactly 16 reads and set the fault bit for the right access type; a swapped selection would flag the wrong output. Parked speculative requests and requests arriving while the result is still held must produce no reads at all. A design that walked early, or that took a new request before the acknowledge, would show extra reads.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int PA_W   = 32;
  localparam int VSID_W = 24;
  localparam int PIDX_W = 16;
  localparam int HASH_W = 19;
  localparam int API_W  = 6;
  localparam int ENT_B  = 8;
  localparam int PTE_W  = 64;

  // upper half of an entry: {valid, vsid, pass, api}
  typedef struct packed {
    logic              v;
    logic [VSID_W-1:0] vsid;
    logic              h;
    logic [API_W-1:0]  api;
  } pte_key_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash
  import hpt_pkg::*;
#(
  parameter int GRP_SH = 6
) (
  input  logic [HASH_W-1:0]    vsid_lo_i,
  input  logic [PIDX_W-1:0]    epi_i,
  input  logic                 sec_i,
  input  logic [PA_W-1:GRP_SH] org_i,
  input  logic [HASH_W-1:0]    mask_i,
  output logic [PA_W-1:0]      base_o
);
  localparam int OW = PA_W - GRP_SH;

  logic [HASH_W-1:0] prim_hash;
  logic [HASH_W-1:0] use_hash;

  always_comb begin
    prim_hash = vsid_lo_i ^ HASH_W'(epi_i);
    use_hash  = sec_i ? ~prim_hash : prim_hash;
    base_o    = {org_i | OW'(use_hash & mask_i), {GRP_SH{1'b0}}};
  end
endmodule

// File: rtl/hpt_match.sv
module hpt_match
  import hpt_pkg::*;
(
  input  pte_key_t           ent_i,
  input  logic [VSID_W-1:0]  vsid_i,
  input  logic [API_W-1:0]   api_i,
  input  logic               pass_i,
  output logic               hit_o
);
  always_comb begin
    hit_o = ent_i.v && (ent_i.vsid == vsid_i) && (ent_i.api == api_i)
            && (ent_i.h == pass_i);
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int ENT_N  = 8,
  parameter int STAT_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic                  req_spec_i,
  input  logic                  req_required_i,
  input  logic                  req_is_inst_i,
  input  logic [VSID_W-1:0]     req_vsid_i,
  input  logic [PIDX_W-1:0]     req_epi_i,
  input  logic [PA_W-1:$clog2(ENT_N*ENT_B)] table_org_i,
  input  logic [HASH_W-1:0]     table_mask_i,
  output logic                  mem_req_valid_o,
  input  logic                  mem_req_ready_i,
  output logic [PA_W-1:0]       mem_req_addr_o,
  input  logic                  mem_rsp_valid_i,
  input  logic [PTE_W-1:0]      mem_rsp_data_i,
  output logic                  done_o,
  input  logic                  done_ack_i,
  output logic                  hit_o,
  output logic [PTE_W-1:0]      pte_o,
  output logic [STAT_W-1:0]     inst_fault_o,
  output logic [STAT_W-1:0]     data_fault_o
);
  localparam int GRP_SH = $clog2(ENT_N * ENT_B);
  localparam int ENT_SH = $clog2(ENT_B);
  localparam int IDX_W  = $clog2(ENT_N);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ENT_N - 1);
  localparam logic [STAT_W-1:0] FLT_BIT = STAT_W'(2);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  walk_st_e          st_q, st_d;
  logic [VSID_W-1:0] vsid_q;
  logic [PIDX_W-1:0] epi_q;
  logic              inst_q;
  logic              sec_q, sec_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              hit_q, hit_d;
  logic [PTE_W-1:0]  pte_q;
  logic [STAT_W-1:0] ifl_q, ifl_d, dfl_q, dfl_d;
  logic              cap_en, pte_en;

  logic [PA_W-1:0]   grp_base;
  logic              ent_hit;

  hpt_hash #(.GRP_SH(GRP_SH)) u_hash (
    .vsid_lo_i (vsid_q[HASH_W-1:0]),
    .epi_i     (epi_q),
    .sec_i     (sec_q),
    .org_i     (table_org_i),
    .mask_i    (table_mask_i),
    .base_o    (grp_base)
  );

  hpt_match u_match (
    .ent_i  (pte_key_t'(mem_rsp_data_i[PTE_W-1:PTE_W/2])),
    .vsid_i (vsid_q),
    .api_i  (epi_q[PIDX_W-1 -: API_W]),
    .pass_i (sec_q),
    .hit_o  (ent_hit)
  );

  // next-state logic
  always_comb begin
    st_d   = st_q;
    sec_d  = sec_q;
    idx_d  = idx_q;
    hit_d  = hit_q;
    ifl_d  = ifl_q;
    dfl_d  = dfl_q;
    cap_en = 1'b0;
    pte_en = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        cap_en = 1'b1;
        sec_d  = 1'b0;
        idx_d  = '0;
        hit_d  = 1'b0;
        ifl_d  = '0;
        dfl_d  = '0;
        st_d   = req_spec_i ? ST_HOLD : ST_ISSUE;
      end
      ST_HOLD:  if (req_required_i) st_d = ST_ISSUE;
      ST_ISSUE: if (mem_req_ready_i) st_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid_i) begin
        if (ent_hit) begin
          hit_d  = 1'b1;
          pte_en = 1'b1;
          st_d   = ST_DONE;
        end else if (idx_q != IDX_LAST) begin
          idx_d = idx_q + IDX_W'(1);
          st_d  = ST_ISSUE;
        end else if (!sec_q) begin
          sec_d = 1'b1;
          idx_d = '0;
          st_d  = ST_ISSUE;
        end else begin
          if (inst_q) ifl_d = FLT_BIT;
          else        dfl_d = FLT_BIT;
          st_d = ST_DONE;
        end
      end
      ST_DONE:  if (done_ack_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      sec_q <= 1'b0;
      idx_q <= '0;
      hit_q <= 1'b0;
      ifl_q <= '0;
      dfl_q <= '0;
    end else begin
      st_q  <= st_d;
      sec_q <= sec_d;
      idx_q <= idx_d;
      hit_q <= hit_d;
      ifl_q <= ifl_d;
      dfl_q <= dfl_d;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      vsid_q <= '0;
      epi_q  <= '0;
      inst_q <= 1'b0;
    end else if (cap_en) begin
      vsid_q <= req_vsid_i;
      epi_q  <= req_epi_i;
      inst_q <= req_is_inst_i;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     pte_q <= '0;
    else if (pte_en) pte_q <= mem_rsp_data_i;
  end

  assign req_ready_o     = (st_q == ST_IDLE);
  assign mem_req_valid_o = (st_q == ST_ISSUE);
  assign mem_req_addr_o  = grp_base | (PA_W'(idx_q) << ENT_SH);
  assign done_o          = (st_q == ST_DONE);
  assign hit_o           = hit_q;
  assign pte_o           = pte_q;
  assign inst_fault_o    = ifl_q;
  assign data_fault_o    = dfl_q;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));
  // R3
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req_valid_o |-> mem_req_addr_o[ENT_SH-1:0] == '0);
  // R6
  hit_clean_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o && hit_o |-> (inst_fault_o == '0) && (data_fault_o == '0));
  // R7
  fault_one_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o && !hit_o |-> $countones({inst_fault_o[1], data_fault_o[1]}) == 1);
  // R9
  spec_park_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    st_q == ST_HOLD |-> !mem_req_valid_o);
  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o && !done_ack_i |=> done_o && $stable(pte_o) && $stable(hit_o));
  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |-> !mem_req_valid_o && !req_ready_o);
endmodule

// File: tb/tb_hpt_walker.sv
module tb_hpt_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_spec, req_required, req_is_inst;
  logic [23:0] req_vsid;
  logic [15:0] req_epi;
  logic [31:6] table_org;
  logic [18:0] table_mask;
  logic        req_ready, mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_req_addr;
  logic [63:0] mem_rsp_data;
  logic        done, done_ack, hit;
  logic [63:0] pte;
  logic [31:0] inst_fault, data_fault;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int rd_n   = 0;
  logic [31:0] rd_addr [0:31];
  logic [63:0] mem [logic [31:0]];
  logic        stall_mode = 1'b0;

  always #5 clk = ~clk;

  hpt_walker dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_spec_i(req_spec), .req_required_i(req_required),
    .req_is_inst_i(req_is_inst), .req_vsid_i(req_vsid), .req_epi_i(req_epi),
    .table_org_i(table_org), .table_mask_i(table_mask),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o(mem_req_addr), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i(mem_rsp_data), .done_o(done), .done_ack_i(done_ack),
    .hit_o(hit), .pte_o(pte), .inst_fault_o(inst_fault), .data_fault_o(data_fault)
  );

  assign mem_req_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_data <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
      if (rd_n < 32) rd_addr[rd_n] <= mem_req_addr;
      rd_n <= rd_n + 1;
    end
  end

  // watchdog
  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run hung (act=timeout exp=finish)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  function automatic logic [31:0] grp(input logic [23:0] v, input logic [15:0] e,
                                      input logic s);
    logic [18:0] h;
    h = v[18:0] ^ {3'b0, e};
    if (s) h = ~h;
    return {table_org | {7'b0, h & table_mask}, 6'b0};
  endfunction

  function automatic logic [63:0] mk(input logic v, input logic [23:0] vs,
                                     input logic h, input logic [5:0] api,
                                     input logic [31:0] pay);
    return {v, vs, h, api, pay};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [23:0] v, input logic [15:0] e,
                       input logic inst, input logic spec);
    @(negedge clk);
    rd_n        = 0;
    req_vsid    = v;
    req_epi     = e;
    req_is_inst = inst;
    req_spec    = spec;
    req_valid   = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_spec  = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 500) begin
      @(negedge clk);
      n++;
    end
    chk(done, tag, {63'b0, done}, 64'h1);
  endtask

  task automatic ack();
    done_ack = 1'b1;
    @(negedge clk);
    done_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk(done == 1'b0, "R1 done", {63'b0, done}, 64'h0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", {63'b0, mem_req_valid}, 64'h0);
    chk(req_ready == 1'b1, "R1 req_ready", {63'b0, req_ready}, 64'h1);
  endtask

  task automatic t_primary_hit();
    logic [23:0] v = 24'hA5_1234;
    logic [15:0] e = 16'hC3F0;
    logic [31:0] b;
    logic [63:0] good;
    mem.delete();
    b = grp(v, e, 1'b0);
    good = mk(1'b1, v, 1'b0, e[15:10], 32'hDEAD_0001);
    mem[b + 32'd8]  = mk(1'b1, v ^ 24'h1, 1'b0, e[15:10], 32'h1);
    mem[b + 32'd16] = mk(1'b0, v, 1'b0, e[15:10], 32'h2);   // invalid: R4
    mem[b + 32'd24] = good;
    issue(v, e, 1'b1, 1'b0);
    wait_done("R6 primary done");
    chk(hit == 1'b1, "R6 hit", {63'b0, hit}, 64'h1);
    chk(pte == good, "R6 pte", pte, good);
    chk(rd_n == 4, "R4 reads up to match", 64'(rd_n), 64'd4);
    chk(rd_addr[0] == b, "R2 primary base", 64'(rd_addr[0]), 64'(b));
    chk(rd_addr[3] == b + 32'd24, "R3 entry stride", 64'(rd_addr[3]), 64'(b + 32'd24));
    chk(inst_fault == 0 && data_fault == 0, "R6 no fault",
        {inst_fault, data_fault}, 64'h0);
    ack();
  endtask

  task automatic t_secondary_hit();
    logic [23:0] v = 24'h00_7777;
    logic [15:0] e = 16'h1357;
    logic [31:0] bp, bs;
    logic [63:0] good;
    bit seq_ok = 1'b1;
    mem.delete();
    bp = grp(v, e, 1'b0);
    bs = grp(v, e, 1'b1);
    good = mk(1'b1, v, 1'b1, e[15:10], 32'hBEEF_0002);
    mem[bp + 32'd40] = mk(1'b1, v, 1'b1, e[15:10], 32'h9);  // H=1 in primary: R4
    mem[bs + 32'd8]  = mk(1'b1, v, 1'b0, e[15:10], 32'h8);  // H=0 in secondary
    mem[bs + 32'd16] = good;
    stall_mode = 1'b1;
    issue(v, e, 1'b0, 1'b0);
    wait_done("R5 secondary done");
    stall_mode = 1'b0;
    chk(hit == 1'b1, "R5 hit", {63'b0, hit}, 64'h1);
    chk(pte == good, "R5 pte", pte, good);
    chk(rd_n == 11, "R5 read count", 64'(rd_n), 64'd11);
    for (int k = 0; k < 8; k++)
      if (rd_addr[k] != bp + 32'(8 * k)) seq_ok = 1'b0;
    chk(seq_ok, "R3 primary order", 64'(rd_addr[7]), 64'(bp + 32'd56));
    chk(rd_addr[8] == bs, "R2 secondary base", 64'(rd_addr[8]), 64'(bs));
    ack();
  endtask

  task automatic t_miss(input logic inst);
    logic [23:0] v = 24'h12_0F0F;
    logic [15:0] e = 16'hFFFF;
    logic [31:0] bs;
    mem.delete();
    bs = grp(v, e, 1'b1);
    issue(v, e, inst, 1'b0);
    wait_done(inst ? "R7 miss done" : "R8 miss done");
    chk(hit == 1'b0, inst ? "R7 hit" : "R8 hit", {63'b0, hit}, 64'h0);
    chk(rd_n == 16, inst ? "R7 reads" : "R8 reads", 64'(rd_n), 64'd16);
    chk(rd_addr[15] == bs + 32'd56, "R5 last secondary entry",
        64'(rd_addr[15]), 64'(bs + 32'd56));
    if (inst)
      chk(inst_fault == 32'h2 && data_fault == 0, "R7 status",
          {inst_fault, data_fault}, {32'h2, 32'h0});
    else
      chk(data_fault == 32'h2 && inst_fault == 0, "R8 status",
          {inst_fault, data_fault}, {32'h0, 32'h2});
    ack();
  endtask

  task automatic t_spec();
    logic [23:0] v = 24'h33_0001;
    logic [15:0] e = 16'h0400;
    logic [31:0] b;
    mem.delete();
    b = grp(v, e, 1'b0);
    mem[b] = mk(1'b1, v, 1'b0, e[15:10], 32'h5);
    issue(v, e, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    chk(rd_n == 0, "R9 no read while parked", 64'(rd_n), 64'd0);
    chk(done == 1'b0, "R9 not done while parked", {63'b0, done}, 64'h0);
    req_required = 1'b1;
    @(negedge clk);
    req_required = 1'b0;
    wait_done("R9 done after confirm");
    chk(hit == 1'b1 && rd_n == 1, "R9 walk after confirm", 64'(rd_n), 64'd1);
    ack();
  endtask

  task automatic t_done_hold();
    logic [23:0] v = 24'h44_4444;
    logic [15:0] e = 16'h8001;
    logic [31:0] b;
    logic [63:0] good;
    int n0;
    mem.delete();
    b = grp(v, e, 1'b0);
    good = mk(1'b1, v, 1'b0, e[15:10], 32'hCAFE_0003);
    mem[b] = good;
    issue(v, e, 1'b1, 1'b0);
    wait_done("R10 done");
    n0 = rd_n;
    req_vsid  = 24'h55_5555;
    req_valid = 1'b1;
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    chk(rd_n == n0, "R10 no reads while held", 64'(rd_n), 64'(n0));
    chk(done && pte == good, "R10 result held", pte, good);
    chk(req_ready == 1'b0, "R10 not ready while held", {63'b0, req_ready}, 64'h0);
    ack();
    chk(done == 1'b0 && req_ready == 1'b1, "R10 idle after ack",
        {62'b0, done, req_ready}, 64'h1);
  endtask

  task automatic t_mask();
    logic [23:0] v = 24'h07_ABCD;
    logic [15:0] e = 16'h2468;
    logic [31:0] b;
    table_mask = 19'h003FF;
    mem.delete();
    b = grp(v, e, 1'b0);
    mem[b + 32'd56] = mk(1'b1, v, 1'b0, e[15:10], 32'h7);
    issue(v, e, 1'b0, 1'b0);
    wait_done("R2 masked done");
    chk(rd_addr[0] == b, "R2 masked base", 64'(rd_addr[0]), 64'(b));
    chk(hit && rd_n == 8, "R3 last primary entry hit", 64'(rd_n), 64'd8);
    ack();
    table_mask = 19'h7FFFF;
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_spec = 1'b0; req_required = 1'b0; req_is_inst = 1'b0;
    req_vsid = '0; req_epi = '0; done_ack = 1'b0;
    table_org = 26'h0004000;
    table_mask = 19'h7FFFF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_primary_hit();
    t_secondary_hit();
    t_miss(1'b1);
    t_miss(1'b0);
    t_spec();
    t_done_hold();
    t_mask();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule